// File: doc/BRIEF.md
# Ping-Pong USB Receive Endpoint Buffer

This block is the receive store of one bulk-out style USB endpoint. It holds two packet buffers that take turns. Bytes arrive from the packet side as a valid/ready stream with an end-of-packet marker, and each packet is written into whichever buffer is next in turn. The CPU side sees one buffer at a time. It gets that buffer's byte count, a read data port that steps through the bytes, and a write-one trigger that hands the buffer back once the packet has been consumed.

The buffers form a two-entry ring. Packets fill the buffers in the order 0, 1, 0, 1, and the CPU drains them in the same order. While the CPU holds one packet, the other buffer can take the next one. When both buffers hold packets, the packet side sees a NAK level, and any packet that starts in that state is swallowed without touching either buffer.

Stream rules: a beat transfers when `pkt_valid` and `pkt_ready` are both high. `pkt_ready` is low only during reset. The block never back-pressures; it refuses a packet by discarding it. Every beat carries one byte, and `pkt_last` marks the final byte of a packet. The accept-or-discard decision for a packet is made on its first beat and holds until its last beat.

Top module: `usb_rx_pingpong`

## Requirements
- R1: After reset, `rx_size` is 0, `rx_avail` is 0, `rx_empty` is 1, `rx_full` is 0, `pkt_nak` is 0 and `rx_ovf` is 0.
- R2: A packet written into a free buffer becomes readable in the clock after its last beat. If the CPU side is waiting on that buffer, `rx_avail` rises and `rx_size` equals the number of bytes in the packet.
- R3: `rx_size` reports the byte count of the buffer the CPU currently sees and never that of the other buffer. When no buffer is selected, `rx_size` is 0.
- R4: `rd_data` shows the byte at the read pointer, and each `rd_strobe` cycle with a buffer selected advances the pointer by one. Bytes come out in the order they were written. The pointer stops at the byte count.
- R5: A trigger write with bit 0 of `trg_wdata` set releases the selected buffer and resets the read pointer to 0. Selection then moves to the other buffer, whose count appears in the next cycle if it holds a packet.
- R6: While the CPU holds one packet, a second packet fills the other buffer. With both buffers occupied, `rx_full` and `pkt_nak` are 1 and `rx_empty` is 0.
- R7: A packet whose first beat arrives while both buffers are occupied is discarded completely. The sizes and contents of both buffers are unchanged.
- R8: A buffer holds at most 64 bytes. The count saturates at 64, further bytes of that packet are dropped, and `rx_ovf` is set and stays set until reset.
- R9: A release trigger while no buffer is selected has no effect on the selection or on later packets.
- R10: Bits of `trg_wdata` other than bit 0 are ignored, and `trg_rdata` always reads 0.
- R11: `pkt_ready` is 1 in every cycle after the first clock out of reset.
- R12: Packets are delivered to the CPU in arrival order, alternating between the two buffers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| pkt_valid | input | 1 | Packet-side beat valid |
| pkt_ready | output | 1 | Packet-side ready (low only in reset) |
| pkt_data | input | 8 | Received byte |
| pkt_last | input | 1 | Marks the final byte of a packet |
| pkt_nak | output | 1 | Both buffers occupied; new packets are refused |
| rd_strobe | input | 1 | Advance the CPU read pointer |
| rd_data | output | 8 | Byte at the CPU read pointer |
| rx_size | output | 8 | Byte count of the selected buffer |
| rx_avail | output | 1 | A full buffer is selected for the CPU |
| trg_wr | input | 1 | Trigger register write strobe |
| trg_wdata | input | 8 | Trigger write data; bit 0 releases the buffer |
| trg_rdata | output | 8 | Trigger register read value (always 0) |
| rx_full | output | 1 | Both buffers occupied |
| rx_empty | output | 1 | Both buffers free |
| rx_ovf | output | 1 | Sticky: a packet exceeded the buffer depth |

## Verification
The bench builds the block with its defaults: 64-byte buffers, 8-bit data and size fields, and the release bit at position 0. The 64-byte depth lets one packet of exactly 64 bytes test the boundary without overflow, and a 70-byte packet drives the count into saturation and raises the sticky overflow flag within a few hundred cycles. Two buffers are few enough that three back-to-back packets reach the both-occupied NAK state and the discard path directly.

// File: rtl/rxpp_pkg.sv
package rxpp_pkg;
  localparam int unsigned NBUF = 2;

  typedef logic buf_sel_t;

  function automatic buf_sel_t other_buf(input buf_sel_t b);
    return ~b;
  endfunction
endpackage

// File: rtl/rxpp_bank.sv
module rxpp_bank
  import rxpp_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DEPTH  = 64,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1),
  localparam int unsigned AW    = $clog2(DEPTH)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  buf_sel_t                    wr_buf,
  input  logic [DATA_W-1:0]           wr_data,
  input  logic                        commit,
  input  buf_sel_t                    commit_buf,
  input  logic                        rel,
  input  buf_sel_t                    rel_buf,
  input  buf_sel_t                    rd_buf,
  input  logic [AW-1:0]               rd_addr,
  output logic [DATA_W-1:0]           rd_data,
  output logic [NBUF-1:0]             full,
  output logic [NBUF-1:0][CNT_W-1:0]  cnt
);

  logic [DATA_W-1:0] rd_word [NBUF];

  for (genvar b = 0; b < NBUF; b++) begin : g_buf
    logic [DATA_W-1:0] mem [DEPTH];
    logic hit_wr, hit_commit, hit_rel;

    assign hit_wr     = wr_en  && (wr_buf     == 1'(b));
    assign hit_commit = commit && (commit_buf == 1'(b));
    assign hit_rel    = rel    && (rel_buf    == 1'(b));

    always_ff @(posedge clk) begin
      if (hit_wr) mem[cnt[b][AW-1:0]] <= wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        full[b] <= 1'b0;
        cnt[b]  <= '0;
      end else if (hit_rel) begin
        full[b] <= 1'b0;
        cnt[b]  <= '0;
      end else begin
        if (hit_commit) full[b] <= 1'b1;
        if (hit_wr)     cnt[b]  <= cnt[b] + CNT_W'(1);
      end
    end

    assign rd_word[b] = mem[rd_addr];

    // R2: a buffer only turns full through a commit aimed at it
    p_full_needs_commit_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(full[b]) |-> $past(commit && (commit_buf == 1'(b))));

    // R8: the count never passes the depth
    p_cnt_limit_r8: assert property (@(posedge clk) disable iff (!rst_n)
      cnt[b] <= CNT_W'(DEPTH));
  end

  assign rd_data = rd_word[rd_buf];

  // R7: with both buffers occupied and nothing released, stored counts hold
  p_hold_when_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((&full) && !rel) |=> $stable(cnt));

endmodule

// File: rtl/rxpp_fill.sv
module rxpp_fill
  import rxpp_pkg::*;
#(
  parameter int unsigned DEPTH  = 64,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pkt_valid,
  input  logic             pkt_last,
  input  logic [NBUF-1:0]  full,
  input  logic [CNT_W-1:0] cnt_tgt,
  output logic             pkt_ready,
  output logic             pkt_nak,
  output logic             wr_en,
  output buf_sel_t         wr_sel,
  output logic             commit,
  output logic             ovf
);

  logic ready_q;
  logic in_pkt;
  logic drop_q;
  logic beat;
  logic drop_now;
  logic room;

  assign pkt_ready = ready_q;
  assign beat      = pkt_valid && ready_q;
  // accept-or-discard is fixed on the first beat of a packet
  assign drop_now  = in_pkt ? drop_q : full[wr_sel];
  assign room      = cnt_tgt < CNT_W'(DEPTH);
  assign wr_en     = beat && !drop_now && room;
  assign commit    = beat && pkt_last && !drop_now;
  assign pkt_nak   = &full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready_q <= 1'b0;
      in_pkt  <= 1'b0;
      drop_q  <= 1'b0;
      wr_sel  <= 1'b0;
      ovf     <= 1'b0;
    end else begin
      ready_q <= 1'b1;
      if (beat) begin
        in_pkt <= !pkt_last;
        drop_q <= drop_now;
        if (!drop_now && !room) ovf <= 1'b1;
      end
      if (commit) wr_sel <= other_buf(wr_sel);
    end
  end

  // R8: the overflow flag is sticky
  p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> ovf);

  // R11: ready stays up once a clock has passed out of reset
  p_ready_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> pkt_ready);

endmodule

// File: rtl/rxpp_drain.sv
module rxpp_drain
  import rxpp_pkg::*;
#(
  parameter int unsigned DEPTH  = 64,
  parameter int unsigned SIZE_W = 8,
  parameter int unsigned TRG_W  = 8,
  parameter int unsigned RC_BIT = 0,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1),
  localparam int unsigned AW    = $clog2(DEPTH)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NBUF-1:0]             full,
  input  logic [NBUF-1:0][CNT_W-1:0]  cnt,
  input  logic                        rd_strobe,
  input  logic                        trg_wr,
  input  logic [TRG_W-1:0]            trg_wdata,
  output buf_sel_t                    rd_sel,
  output logic [AW-1:0]               rd_addr,
  output logic                        sel_valid,
  output logic [SIZE_W-1:0]           size,
  output logic                        rel
);

  logic [CNT_W-1:0] rd_ptr;
  logic [CNT_W-1:0] cnt_sel;
  logic             trg_unused;

  assign trg_unused = ^trg_wdata;
  assign cnt_sel    = cnt[rd_sel];
  assign sel_valid  = full[rd_sel];
  assign rel        = trg_wr && trg_wdata[RC_BIT] && sel_valid;
  assign size       = sel_valid ? SIZE_W'(cnt_sel) : '0;
  assign rd_addr    = rd_ptr[AW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_sel <= 1'b0;
      rd_ptr <= '0;
    end else if (rel) begin
      rd_sel <= other_buf(rd_sel);
      rd_ptr <= '0;
    end else if (rd_strobe && sel_valid && (rd_ptr < cnt_sel)) begin
      rd_ptr <= rd_ptr + CNT_W'(1);
    end
  end

  // R5: release rewinds the read pointer
  p_ptr_rewind_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rel |=> (rd_ptr == '0));

  // R9: a trigger with nothing selected leaves the selection alone
  p_idle_trigger_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (trg_wr && !sel_valid) |=> $stable(rd_sel));

  // R4: the pointer never runs past the stored count
  p_ptr_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ptr <= cnt_sel);

endmodule

// File: rtl/usb_rx_pingpong.sv
module usb_rx_pingpong
  import rxpp_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DEPTH  = 64,
  parameter int unsigned SIZE_W = 8,
  parameter int unsigned TRG_W  = 8,
  parameter int unsigned RC_BIT = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pkt_valid,
  output logic              pkt_ready,
  input  logic [DATA_W-1:0] pkt_data,
  input  logic              pkt_last,
  output logic              pkt_nak,
  input  logic              rd_strobe,
  output logic [DATA_W-1:0] rd_data,
  output logic [SIZE_W-1:0] rx_size,
  output logic              rx_avail,
  input  logic              trg_wr,
  input  logic [TRG_W-1:0]  trg_wdata,
  output logic [TRG_W-1:0]  trg_rdata,
  output logic              rx_full,
  output logic              rx_empty,
  output logic              rx_ovf
);

  localparam int unsigned CNT_W = $clog2(DEPTH + 1);
  localparam int unsigned AW    = $clog2(DEPTH);

  logic [NBUF-1:0]            full;
  logic [NBUF-1:0][CNT_W-1:0] cnt;
  logic                       wr_en;
  buf_sel_t                   wr_sel;
  logic                       commit;
  logic                       rel;
  buf_sel_t                   rd_sel;
  logic [AW-1:0]              rd_addr;

  rxpp_fill #(.DEPTH(DEPTH)) u_fill (
    .clk      (clk),
    .rst_n    (rst_n),
    .pkt_valid(pkt_valid),
    .pkt_last (pkt_last),
    .full     (full),
    .cnt_tgt  (cnt[wr_sel]),
    .pkt_ready(pkt_ready),
    .pkt_nak  (pkt_nak),
    .wr_en    (wr_en),
    .wr_sel   (wr_sel),
    .commit   (commit),
    .ovf      (rx_ovf)
  );

  rxpp_bank #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_buf    (wr_sel),
    .wr_data   (pkt_data),
    .commit    (commit),
    .commit_buf(wr_sel),
    .rel       (rel),
    .rel_buf   (rd_sel),
    .rd_buf    (rd_sel),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data),
    .full      (full),
    .cnt       (cnt)
  );

  rxpp_drain #(
    .DEPTH (DEPTH),
    .SIZE_W(SIZE_W),
    .TRG_W (TRG_W),
    .RC_BIT(RC_BIT)
  ) u_drain (
    .clk      (clk),
    .rst_n    (rst_n),
    .full     (full),
    .cnt      (cnt),
    .rd_strobe(rd_strobe),
    .trg_wr   (trg_wr),
    .trg_wdata(trg_wdata),
    .rd_sel   (rd_sel),
    .rd_addr  (rd_addr),
    .sel_valid(rx_avail),
    .size     (rx_size),
    .rel      (rel)
  );

  assign trg_rdata = '0;
  assign rx_full   = &full;
  assign rx_empty  = ~|full;

  // R3: nothing selected means a zero size at the port
  p_size_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_avail |-> (rx_size == '0));

  // R6: the NAK level coincides with both buffers occupied
  p_nak_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_nak |-> (rx_full && !rx_empty));

endmodule

// File: tb/usb_rx_pingpong_tb_top.sv
module usb_rx_pingpong_tb_top;

  typedef struct packed {
    logic [7:0] len;
    logic [7:0] base;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VEC [NV] = '{
    '{8'd1,  8'h10},
    '{8'd5,  8'hA0},
    '{8'd64, 8'h00},
    '{8'd17, 8'hF8},
    '{8'd2,  8'h7F},
    '{8'd33, 8'h55}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pkt_valid = 1'b0;
  logic       pkt_ready;
  logic [7:0] pkt_data = '0;
  logic       pkt_last = 1'b0;
  logic       pkt_nak;
  logic       rd_strobe = 1'b0;
  logic [7:0] rd_data;
  logic [7:0] rx_size;
  logic       rx_avail;
  logic       trg_wr = 1'b0;
  logic [7:0] trg_wdata = '0;
  logic [7:0] trg_rdata;
  logic       rx_full;
  logic       rx_empty;
  logic       rx_ovf;

  int n_chk = 0;
  int n_err = 0;

  always #4 clk = ~clk;

  usb_rx_pingpong dut_i (
    .clk(clk), .rst_n(rst_n),
    .pkt_valid(pkt_valid), .pkt_ready(pkt_ready), .pkt_data(pkt_data),
    .pkt_last(pkt_last), .pkt_nak(pkt_nak),
    .rd_strobe(rd_strobe), .rd_data(rd_data), .rx_size(rx_size),
    .rx_avail(rx_avail), .trg_wr(trg_wr), .trg_wdata(trg_wdata),
    .trg_rdata(trg_rdata), .rx_full(rx_full), .rx_empty(rx_empty),
    .rx_ovf(rx_ovf)
  );

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic send(input int len, input logic [7:0] base);
    for (int i = 0; i < len; i++) begin
      pkt_valid = 1'b1;
      pkt_data  = 8'(base + i);
      pkt_last  = (i == len - 1);
      @(negedge clk);
    end
    pkt_valid = 1'b0;
    pkt_last  = 1'b0;
  endtask

  task automatic drain(input int n, input logic [7:0] base, input string what);
    int bad = 0;
    for (int i = 0; i < n; i++) begin
      if (rd_data !== 8'(base + i)) begin
        if (bad == 0) chk(what, rd_data, 8'(base + i));
        bad++;
      end
      rd_strobe = 1'b1;
      @(negedge clk);
      rd_strobe = 1'b0;
    end
    if (bad == 0) chk(what, 0, 0);
  endtask

  task automatic trig(input logic [7:0] v);
    trg_wdata = v;
    trg_wr    = 1'b1;
    @(negedge clk);
    trg_wr    = 1'b0;
    trg_wdata = '0;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 size", rx_size, 0);
    chk("R1 avail", rx_avail, 0);
    chk("R1 empty", rx_empty, 1);
    chk("R1 full", rx_full, 0);
    chk("R1 nak", pkt_nak, 0);
    chk("R1 ovf", rx_ovf, 0);
    // R11 ready after reset
    chk("R11 ready", pkt_ready, 1);

    // table walk: R2, R4, R5, R12
    for (int v = 0; v < NV; v++) begin
      send(int'(VEC[v].len), VEC[v].base);
      chk("R2 avail", rx_avail, 1);
      chk("R2 size", rx_size, VEC[v].len);
      drain(int'(VEC[v].len), VEC[v].base, "R4 data");
      trig(8'h01);
      chk("R5 empty after release", rx_empty, 1);
      chk("R3 size zero when none", rx_size, 0);
    end
    chk("R8 no ovf at exact depth", rx_ovf, 0);

    // R6 two packets held, R12 order
    send(3, 8'h01);
    send(4, 8'h20);
    chk("R6 full", rx_full, 1);
    chk("R6 nak", pkt_nak, 1);
    chk("R6 empty", rx_empty, 0);
    chk("R3 size of selected only", rx_size, 3);
    // R7 discarded packet
    send(5, 8'h99);
    chk("R7 size unchanged", rx_size, 3);
    chk("R7 still full", rx_full, 1);
    drain(3, 8'h01, "R7 first buffer data");
    trig(8'h01);
    // R5 selection moves to the other, already full buffer
    chk("R5 avail next", rx_avail, 1);
    chk("R12 second size", rx_size, 4);
    chk("R6 nak cleared", pkt_nak, 0);
    drain(4, 8'h20, "R12 second buffer data");
    trig(8'h01);
    chk("R5 empty", rx_empty, 1);

    // R9 idle trigger
    trig(8'h01);
    trig(8'hFF);
    send(2, 8'h40);
    chk("R9 avail after idle trigger", rx_avail, 1);
    chk("R9 size", rx_size, 2);
    // R10 other bits ignored, read back zero
    trig(8'hFE);
    chk("R10 avail held", rx_avail, 1);
    chk("R10 size held", rx_size, 2);
    chk("R10 rdata", trg_rdata, 0);
    drain(2, 8'h40, "R10 data held");
    trig(8'h01);
    chk("R10 released by bit 0", rx_empty, 1);

    // R4 pointer stops at count
    send(2, 8'h60);
    drain(2, 8'h60, "R4 two bytes");
    rd_strobe = 1'b1;
    @(negedge clk);
    rd_strobe = 1'b0;
    chk("R4 size after extra strobe", rx_size, 2);
    trig(8'h01);
    send(1, 8'h70);
    drain(1, 8'h70, "R4 pointer rewound");
    trig(8'h01);

    // R8 overflow
    send(70, 8'hC0);
    chk("R8 saturated size", rx_size, 64);
    chk("R8 ovf set", rx_ovf, 1);
    drain(64, 8'hC0, "R8 stored bytes");
    trig(8'h01);
    chk("R8 ovf sticky", rx_ovf, 1);
    chk("R11 ready", pkt_ready, 1);

    finish_run();
  end

endmodule